// File: doc/BRIEF.md
# Masked Column-Count Dot-Product Engine

This block holds a 32 by 32 tile of single-bit cells and computes dot products without any AND gates. It does this by counting ones in columns of the tile. The 32 columns form four lanes of 8 columns each. Row r of a lane holds one 8-bit element of a stored vector. The other operand vector is streamed in one bit-slice at a time, least significant bit first. Bit r of a slice enables row r of the tile. For every column, the block counts the ones inside the enabled rows, and all columns are counted in the same cycle. Each slice's 6-bit column counts go into a scratch area below the tile as compressed rows. These rows are shifted by the slice position and by the bit weight of each count bit.

Once all 8 slices have been written, the block reduces the scratch area over and over. Every pass counts the ones in each scratch column and writes the counts back in place of the old rows. The passes stop when only two rows are left, and a plain two-operand adder then forms each lane's result. The engine can also run with every row enabled, which makes it add up all the elements of each lane. In that summing mode the elements may be treated as two's complement and sign-extended before the reduction.

Software first loads rows through a valid/ready port. It then issues a command, feeds the slices and collects the four lane results. All three input streams are accepted only on a cycle where both valid and ready are high. The source must hold its data stable while valid is high and ready is low. The result stream holds its data until the consumer raises ready.

Top module: `mcount_dot_engine`

## Requirements
- R1: A load is taken when ld_valid and ld_ready are both high. It writes ld_data into tile row ld_row, and bits [8l+7:8l] of the row are that row's element in lane l. ld_ready is high only while no command is in progress or waiting to deliver its result.
- R2: A command is taken when cmd_valid and cmd_ready are both high. cmd_ready is high only while idle. After a command is taken, busy is high and cmd_ready is low from the next cycle on, until the result is handed over.
- R3: With cmd_sum=0 the engine takes exactly 8 slices through sl_valid/sl_ready, least significant bit first. Bit r of slice k is bit k of multiplier element A[r]. Each lane's result is the sum over r of A[r]*B[r] in that lane, with both operands unsigned.
- R4: A row whose multiplier element is zero contributes nothing to the result, whatever the row holds.
- R5: With cmd_sum=1 no slice is taken: sl_ready stays low. Each lane's result is the unsigned sum of all 32 of its row elements.
- R6: With cmd_sum=1 and cmd_signed=1, every element is read as an 8-bit two's-complement number. The lane result is the signed sum, given in 21-bit two's complement.
- R7: With cmd_sum=0, cmd_signed has no effect on the result.
- R8: res_valid stays high and res_data stays unchanged until res_ready is high. The cycle after the handover, res_valid is low and cmd_ready is high.
- R9: Each lane result is 21 bits wide, at res_data[21l+20:21l], and is exact for every unsigned input, up to 32*255*255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Row load request |
| ld_ready | output | 1 | Row load can be taken |
| ld_row | input | 5 | Row index to write |
| ld_data | input | 32 | Row contents, four 8-bit lane elements |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_sum | input | 1 | 1: sum all rows, 0: dot product with streamed slices |
| cmd_signed | input | 1 | Two's-complement elements in sum mode |
| sl_valid | input | 1 | Slice present |
| sl_ready | output | 1 | Slice can be taken |
| sl_bits | input | 32 | Row enables for one multiplier bit position |
| res_valid | output | 1 | Lane results available |
| res_ready | input | 1 | Consumer takes the results |
| res_data | output | 84 | Four 21-bit lane results |
| busy | output | 1 | Command in progress or result pending |

## Verification
On every cycle the assertions check the handshake rules. A held result must not change while it waits, and it must go away right after the handover. Loads and commands are refused while a command is in progress. Summing mode never asks for a slice. Whether the values are right can only be shown by the bench's scenarios. The bench compares each lane against dot products and sums it works out itself. It uses random vectors, the all-ones worst case, rows masked off while holding nonzero data, the sign flag set during a dot product, and signed sums down to the most negative value.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SLICE, ST_REDUCE, ST_FINAL, ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    LOP_HOLD, LOP_CLEAR, LOP_SLICE, LOP_REDUCE, LOP_FINAL
  } lane_op_e;

  // number of bits needed to hold a count of n ones
  function automatic int unsigned bits_for(input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 31; i++)
      if ((32'd1 << i) <= n) r = i + 1;
    return r;
  endfunction

endpackage

// File: rtl/mcd_tile.sv
module mcd_tile #(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  localparam int AW = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_row,
  input  logic [COLS-1:0]      wr_data,
  output logic [ROWS*COLS-1:0] cells
);
  logic [COLS-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (wr_en) begin
      mem[wr_row] <= wr_data;
    end
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) cells[r*COLS +: COLS] = mem[r];
  end
endmodule

// File: rtl/mcd_seq.sv
module mcd_seq
  import mcd_pkg::*;
#(
  parameter int ROWS    = 32,
  parameter int OPW     = 8,
  parameter int CNT_W   = 6,
  parameter int SC_ROWS = 48,
  localparam int KW     = $clog2(OPW),
  localparam int LIVE_W = $clog2(SC_ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_sum,
  input  logic            cmd_signed,
  input  logic            sl_valid,
  input  logic [ROWS-1:0] sl_bits,
  input  logic            res_ready,
  output logic            cmd_ready,
  output logic            sl_ready,
  output logic            ld_ready,
  output logic            res_valid,
  output logic            busy,
  output lane_op_e        op,
  output logic [KW-1:0]   slice_k,
  output logic [ROWS-1:0] row_en,
  output logic            sign_ext
);
  seq_state_e        state;
  logic [KW-1:0]     k;
  logic [LIVE_W-1:0] live, live_nx;
  logic              is_sum, is_signed;

  assign live_nx   = LIVE_W'(bits_for(32'(live)));
  assign cmd_ready = (state == ST_IDLE);
  assign ld_ready  = (state == ST_IDLE);
  assign sl_ready  = (state == ST_SLICE) && !is_sum;
  assign res_valid = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);
  assign slice_k   = k;
  assign sign_ext  = is_sum & is_signed;

  always_comb begin
    op     = LOP_HOLD;
    row_en = sl_bits;
    unique case (state)
      ST_IDLE:   if (cmd_valid) op = LOP_CLEAR;
      ST_SLICE: begin
        if (is_sum) begin
          op     = LOP_SLICE;
          row_en = '1;
        end else if (sl_valid) begin
          op = LOP_SLICE;
        end
      end
      ST_REDUCE: op = LOP_REDUCE;
      ST_FINAL:  op = LOP_FINAL;
      default:   op = LOP_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      k         <= '0;
      live      <= '0;
      is_sum    <= 1'b0;
      is_signed <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          is_sum    <= cmd_sum;
          is_signed <= cmd_signed;
          k         <= '0;
          state     <= ST_SLICE;
        end
        ST_SLICE: begin
          if (is_sum) begin
            live  <= LIVE_W'(CNT_W);
            state <= ST_REDUCE;
          end else if (sl_valid) begin
            k <= k + 1'b1;
            if (k == KW'(OPW - 1)) begin
              live  <= LIVE_W'(SC_ROWS);
              state <= ST_REDUCE;
            end
          end
        end
        ST_REDUCE: begin
          live <= live_nx;
          if (live_nx <= LIVE_W'(2)) state <= ST_FINAL;
        end
        ST_FINAL: state <= ST_DONE;
        default:  if (res_ready) state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcd_lane.sv
module mcd_lane
  import mcd_pkg::*;
#(
  parameter int ROWS    = 32,
  parameter int OPW     = 8,
  parameter int RES_W   = 21,
  parameter int CNT_W   = 6,
  parameter int SC_ROWS = 48,
  localparam int KW     = $clog2(OPW),
  localparam int SC_CW  = $clog2(SC_ROWS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lane_op_e            op,
  input  logic [KW-1:0]       slice_k,
  input  logic [ROWS-1:0]     row_en,
  input  logic                sign_ext,
  input  logic [ROWS*OPW-1:0] cells,
  output logic [RES_W-1:0]    sum
);
  logic [RES_W-1:0] sc [SC_ROWS];
  logic [CNT_W-1:0] dcnt [RES_W];
  logic [SC_CW-1:0] rcnt [RES_W];
  logic [RES_W-1:0] sv [CNT_W];
  logic [RES_W-1:0] sw [CNT_W];
  logic [RES_W-1:0] rv [SC_CW];
  logic [RES_W-1:0] rw [SC_CW];

  // masked count per column; columns above OPW repeat the sign column
  always_comb begin
    for (int c = 0; c < RES_W; c++) begin
      dcnt[c] = '0;
      for (int r = 0; r < ROWS; r++)
        dcnt[c] = dcnt[c] + CNT_W'(row_en[r]
                  & cells[r*OPW + ((c < OPW) ? c : OPW - 1)]
                  & ((c < OPW) | sign_ext));
    end
  end

  // unmasked count per column over the scratch rows
  always_comb begin
    for (int c = 0; c < RES_W; c++) begin
      rcnt[c] = '0;
      for (int i = 0; i < SC_ROWS; i++)
        rcnt[c] = rcnt[c] + SC_CW'(sc[i][c]);
    end
  end

  always_comb begin
    for (int b = 0; b < CNT_W; b++)
      for (int c = 0; c < RES_W; c++) sv[b][c] = dcnt[c][b];
    for (int b = 0; b < SC_CW; b++)
      for (int c = 0; c < RES_W; c++) rv[b][c] = rcnt[c][b];
  end

  for (genvar b = 0; b < CNT_W; b++) begin : g_sw
    assign sw[b] = sv[b] << (32'(slice_k) + b);
  end
  for (genvar b = 0; b < SC_CW; b++) begin : g_rw
    assign rw[b] = rv[b] << b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SC_ROWS; i++) sc[i] <= '0;
      sum <= '0;
    end else begin
      unique case (op)
        LOP_CLEAR:
          for (int i = 0; i < SC_ROWS; i++) sc[i] <= '0;
        LOP_SLICE:
          for (int i = 0; i < SC_ROWS; i++)
            for (int b = 0; b < CNT_W; b++)
              if (i == int'(slice_k) * CNT_W + b) sc[i] <= sw[b];
        LOP_REDUCE:
          for (int i = 0; i < SC_ROWS; i++)
            sc[i] <= (i < SC_CW) ? rw[i] : '0;
        LOP_FINAL:
          sum <= sc[0] + sc[1];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcount_dot_engine.sv
module mcount_dot_engine
  import mcd_pkg::*;
#(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  parameter int OPW  = 8,
  localparam int LANES   = COLS / OPW,
  localparam int AW      = $clog2(ROWS),
  localparam int KW      = $clog2(OPW),
  localparam int CNT_W   = $clog2(ROWS + 1),
  localparam int RES_W   = 2 * OPW + $clog2(ROWS),
  localparam int SC_ROWS = OPW * CNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  output logic                   ld_ready,
  input  logic [AW-1:0]          ld_row,
  input  logic [COLS-1:0]        ld_data,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic                   cmd_sum,
  input  logic                   cmd_signed,
  input  logic                   sl_valid,
  output logic                   sl_ready,
  input  logic [ROWS-1:0]        sl_bits,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [LANES*RES_W-1:0] res_data,
  output logic                   busy
);
  logic [ROWS*COLS-1:0] cells;
  lane_op_e             op;
  logic [KW-1:0]        slice_k;
  logic [ROWS-1:0]      row_en;
  logic                 sign_ext;

  mcd_tile #(.ROWS(ROWS), .COLS(COLS)) u_tile (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_valid & ld_ready),
    .wr_row(ld_row), .wr_data(ld_data), .cells(cells)
  );

  mcd_seq #(.ROWS(ROWS), .OPW(OPW), .CNT_W(CNT_W), .SC_ROWS(SC_ROWS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sum(cmd_sum),
    .cmd_signed(cmd_signed), .sl_valid(sl_valid), .sl_bits(sl_bits),
    .res_ready(res_ready), .cmd_ready(cmd_ready), .sl_ready(sl_ready),
    .ld_ready(ld_ready), .res_valid(res_valid), .busy(busy), .op(op),
    .slice_k(slice_k), .row_en(row_en), .sign_ext(sign_ext)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ROWS*OPW-1:0] lane_cells;
    always_comb begin
      for (int r = 0; r < ROWS; r++)
        lane_cells[r*OPW +: OPW] = cells[r*COLS + l*OPW +: OPW];
    end
    mcd_lane #(.ROWS(ROWS), .OPW(OPW), .RES_W(RES_W), .CNT_W(CNT_W),
               .SC_ROWS(SC_ROWS)) u_lane (
      .clk(clk), .rst_n(rst_n), .op(op), .slice_k(slice_k), .row_en(row_en),
      .sign_ext(sign_ext), .cells(lane_cells), .sum(res_data[l*RES_W +: RES_W])
    );
  end
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
  parameter int DW = 84
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_sum,
  input logic          sl_ready,
  input logic          ld_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          busy
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid && cmd_ready);

  p_load_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !ld_ready && !cmd_ready);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy && !cmd_ready && !ld_ready);

  p_noslice_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_sum |=> !sl_ready);

  p_slice_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sl_ready |-> busy && !res_valid);
endmodule

bind mcount_dot_engine mcd_checker #(.DW(LANES * RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_sum(cmd_sum), .sl_ready(sl_ready), .ld_ready(ld_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .busy(busy)
);

// File: tb/sim_mcount_dot_engine.sv
module sim_mcount_dot_engine;
  localparam int ROWS  = 32;
  localparam int COLS  = 32;
  localparam int OPW   = 8;
  localparam int LANES = 4;
  localparam int RES_W = 21;
  localparam int DW    = LANES * RES_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, cmd_valid = 1'b0, cmd_sum = 1'b0, cmd_signed = 1'b0;
  logic sl_valid = 1'b0, res_ready = 1'b0;
  logic [4:0] ld_row = '0;
  logic [COLS-1:0] ld_data = '0;
  logic [ROWS-1:0] sl_bits = '0;
  logic ld_ready, cmd_ready, sl_ready, res_valid, busy;
  logic [DW-1:0] res_data;

  always #10 clk = ~clk;

  mcount_dot_engine u0 (.*);

  int errors = 0;
  int checks = 0;
  int a_v [ROWS];
  int b_v [ROWS][LANES];
  logic [DW-1:0] exp_q [$];
  string tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected lane values computed from the requirements
  function automatic logic [DW-1:0] model(input bit sum_m, input bit sgn);
    logic [DW-1:0] e;
    e = '0;
    for (int l = 0; l < LANES; l++) begin
      int acc;
      logic [31:0] t;
      acc = 0;
      for (int r = 0; r < ROWS; r++) begin
        if (!sum_m) acc += a_v[r] * b_v[r][l];
        else if (sgn && b_v[r][l] > 127) acc += b_v[r][l] - 256;
        else acc += b_v[r][l];
      end
      t = acc;
      e[l*RES_W +: RES_W] = t[RES_W-1:0];
    end
    return e;
  endfunction

  task automatic run(input bit sum_m, input bit sgn, input string tag);
    while (busy || exp_q.size() != 0) @(negedge clk);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_row = 5'(r);
      for (int l = 0; l < LANES; l++) ld_data[l*OPW +: OPW] = 8'(b_v[r][l]);
    end
    @(negedge clk);
    ld_valid = 1'b0;
    exp_q.push_back(model(sum_m, sgn));
    tag_q.push_back(tag);
    cmd_valid = 1'b1; cmd_sum = sum_m; cmd_signed = sgn;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R2 busy after command", {busy, cmd_ready}, 2'b10);
    if (sum_m) begin
      for (int i = 0; i < 2; i++) begin
        chk(!sl_ready, "R5 no slice requested", sl_ready, 0);
        @(negedge clk);
      end
    end else begin
      for (int k = 0; k < OPW; k++) begin
        repeat ($urandom % 3) @(negedge clk);
        sl_valid = 1'b1;
        for (int r = 0; r < ROWS; r++) sl_bits[r] = a_v[r][k];
        while (!sl_ready) @(negedge clk);
        @(negedge clk);
        sl_valid = 1'b0;
      end
    end
  endtask

  task automatic fill(input int amax, input int bmax, input bit rnd);
    for (int r = 0; r < ROWS; r++) begin
      a_v[r] = rnd ? int'($urandom % (amax + 1)) : amax;
      for (int l = 0; l < LANES; l++)
        b_v[r][l] = rnd ? int'($urandom % (bmax + 1)) : bmax;
    end
  endtask

  // monitor: pops the scoreboard when results appear
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        logic [DW-1:0] snap, e;
        string t;
        snap = res_data;
        chk(!ld_ready && !cmd_ready, "R1 load refused while result pending",
            {ld_ready, cmd_ready}, 0);
        repeat (1 + $urandom % 3) begin
          @(negedge clk);
          chk(res_valid && res_data == snap, "R8 result held", res_data, snap);
        end
        res_ready = 1'b1;
        if (exp_q.size() != 0) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
        end else begin
          e = 'x;
          t = "no expected item";
        end
        chk(res_data === e, t, res_data, e);
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid && cmd_ready, "R8 released after handover",
            {res_valid, cmd_ready}, 2'b01);
      end
    end
  end

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!res_valid && cmd_ready && ld_ready && !sl_ready && !busy,
            "R2 reset state", {res_valid, cmd_ready, ld_ready, sl_ready, busy},
            5'b01100);
        for (int n = 0; n < 3; n++) begin
          fill(255, 255, 1'b1);
          run(1'b0, 1'b0, "R3 random dot product");
        end
        fill(255, 255, 1'b0);
        run(1'b0, 1'b0, "R9 all-ones worst case");
        fill(255, 255, 1'b1);
        for (int r = 8; r < ROWS; r++) begin
          a_v[r] = 0;
          for (int l = 0; l < LANES; l++) b_v[r][l] = 255;
        end
        run(1'b0, 1'b0, "R4 masked rows ignored");
        fill(0, 255, 1'b0);
        run(1'b0, 1'b0, "R4 zero multiplier");
        fill(255, 255, 1'b1);
        run(1'b0, 1'b1, "R7 sign flag ignored in dot mode");
        fill(255, 255, 1'b1);
        run(1'b1, 1'b0, "R5 unsigned sum");
        fill(0, 255, 1'b0);
        run(1'b1, 1'b0, "R5 unsigned sum of maxima");
        fill(255, 255, 1'b1);
        run(1'b1, 1'b1, "R6 signed sum");
        fill(0, 128, 1'b0);
        run(1'b1, 1'b1, "R6 most negative sum");
        while (busy || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=busy expected=idle");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule